// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects interrupt requests for a small processor core and turns them into one vectored request. Eight levels exist; each has a fixed priority and a fixed service-routine address in program ROM. A request may come from a hardware line (internal or external source) or from a software strobe issued by the core, which names the level it wants to raise. Every request is captured in a per-level pending latch. The latch stays set until the core acknowledges that level.

Each level can be blocked by its own mask bit. A global enable flag, held in the controller, decides whether the core is interrupted at all. While the flag is clear, requests still accumulate in the latches. They are presented as soon as the flag is set again. When the core accepts an interrupt, the flag drops automatically. A return-from-service strobe sets it again.

The vector table starts at a base address and uses a constant stride per level. Both values are parameters. With the defaults, level n maps to 0x040 + 8·n.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no level is pending, the global enable `ien_o` is 0, `irq_o` is 0, and `vec_o` and `lvl_o` are 0.
- R2: If `req_i[n]` is 1 at a rising clock edge, level n is pending from that edge onward. The request line needs to be high for only one edge.
- R3: If `swi_i` is 1 at an edge, the level numbered by `swi_lvl_i` (binary, 0 to 7) becomes pending, exactly as if its hardware request had been raised.
- R4: A pending level is never lost while `ien_o` is 0. `irq_o` stays 0 in that state, and it rises in the cycle after the enable is set, with no new request needed.
- R5: `mask_i[n]` = 1 removes level n from selection but leaves its pending latch untouched. Clearing the mask bit makes the level eligible again at once.
- R6: Among pending, unmasked levels, the highest-numbered level wins. `lvl_o` gives its number and `vec_o` gives 0x040 + 8·`lvl_o`. When no level is eligible, both outputs are 0.
- R7: `ack_i` = 1 while `irq_o` = 1 clears only the pending latch of the level shown on `lvl_o`. A new request for that same level at the same edge keeps the latch set. `ack_i` while `irq_o` = 0 has no effect on any latch.
- R8: An accepted acknowledge clears `ien_o` at that edge. Otherwise `ien_clr_i` clears the flag, and it takes precedence over `ien_set_i` and `ret_i`. Either of `ien_set_i` or `ret_i` sets the flag.
- R9: `irq_o` is 1 exactly when `ien_o` is 1 and at least one level is pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Hardware request per level, sampled each edge |
| swi_i | input | 1 | Software interrupt strobe |
| swi_lvl_i | input | 3 | Level raised by the software strobe |
| mask_i | input | 8 | Per-level block, 1 = blocked |
| ien_set_i | input | 1 | Set the global enable |
| ien_clr_i | input | 1 | Clear the global enable |
| ack_i | input | 1 | Core accepts the presented vector |
| ret_i | input | 1 | Core returns from service; sets the global enable |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 12 | ROM address of the winning service routine |
| lvl_o | output | 3 | Number of the winning level |
| ien_o | output | 1 | Current global enable flag |

## Verification
Directed cases come first. Requests are latched with the enable clear, which separates latching from presentation. A high and a low level are raised together, with the high one then masked, which separates priority from masking. An acknowledge arrives together with a fresh request for the same level, which shows whether set or clear wins. The enable set and clear strobes are pulsed together, which exposes their precedence. The directed cases are followed by seeded random traffic with sparse request patterns and frequent acknowledges and mask changes. The random phase catches wrong winner selection or lost latches when many levels overlap.

// File: rtl/irq_pkg.sv
package irq_pkg;

   // Requested change of the global enable flag for the next edge
   typedef enum logic [1:0] {
      IEN_HOLD = 2'd0,
      IEN_SET  = 2'd1,
      IEN_DROP = 2'd2
   } ien_op_e;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned N_LVL = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_LVL-1:0] set_i,
   input  logic [N_LVL-1:0] clr_i,
   output logic [N_LVL-1:0] pend_o
);

   generate
      for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pend_o[g] <= 1'b0;
            else if (set_i[g])   pend_o[g] <= 1'b1;   // a new request beats a clear
            else if (clr_i[g])   pend_o[g] <= 1'b0;
         end

         p_latch_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_o[g]);
         p_no_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[g] && !clr_i[g]) |=> pend_o[g]);
         p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !pend_o[g]);
      end
   endgenerate

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int unsigned N_LVL     = 8,
   parameter bit          HIGH_WINS = 1'b1,
   localparam int unsigned LW       = $clog2(N_LVL)
) (
   input  logic [N_LVL-1:0] elig_i,
   output logic             valid_o,
   output logic [LW-1:0]    idx_o
);

   assign valid_o = |elig_i;

   generate
      if (HIGH_WINS) begin : g_high
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < N_LVL; i++)
               if (elig_i[i]) idx_o = LW'(i);
         end
      end else begin : g_low
         always_comb begin
            idx_o = '0;
            for (int i = N_LVL - 1; i >= 0; i--)
               if (elig_i[i]) idx_o = LW'(i);
         end
      end
   endgenerate

   always_comb begin
      if (valid_o) begin
         p_winner_eligible_r6: assert (elig_i[idx_o]);
      end
   end

endmodule

// File: rtl/irq_gate_ctl.sv
module irq_gate_ctl
   import irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic take_i,
   input  logic set_i,
   input  logic ret_i,
   input  logic clr_i,
   output logic ien_o
);

   ien_op_e op;

   always_comb begin
      if (take_i || clr_i)     op = IEN_DROP;
      else if (set_i || ret_i) op = IEN_SET;
      else                     op = IEN_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ien_o <= 1'b0;
      else begin
         case (op)
            IEN_SET:  ien_o <= 1'b1;
            IEN_DROP: ien_o <= 1'b0;
            default:  ien_o <= ien_o;
         endcase
      end
   end

   p_ret_restores_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !clr_i && !take_i) |=> ien_o);
   p_clr_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !ien_o);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int unsigned N_LVL      = 8,
   parameter int unsigned VEC_W      = 12,
   parameter int unsigned VEC_BASE   = 32'h040,
   parameter int unsigned VEC_STRIDE = 8,
   parameter bit          HIGH_WINS  = 1'b1,
   localparam int unsigned LW        = $clog2(N_LVL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_LVL-1:0] req_i,
   input  logic             swi_i,
   input  logic [LW-1:0]    swi_lvl_i,
   input  logic [N_LVL-1:0] mask_i,
   input  logic             ien_set_i,
   input  logic             ien_clr_i,
   input  logic             ack_i,
   input  logic             ret_i,
   output logic             irq_o,
   output logic [VEC_W-1:0] vec_o,
   output logic [LW-1:0]    lvl_o,
   output logic             ien_o
);

   generate
      if (N_LVL < 2 || (1 << LW) != N_LVL) begin : g_bad_lvl
         $error("prio_irq_ctrl: N_LVL must be a power of two, at least 2");
      end
      if (VEC_BASE + (N_LVL - 1) * VEC_STRIDE >= (64'd1 << VEC_W)) begin : g_bad_vec
         $error("prio_irq_ctrl: vector table does not fit VEC_W");
      end
   endgenerate

   logic [N_LVL-1:0] pend, elig, set_v, clr_v, swi_dec;
   logic             sel_valid, take;
   logic [LW-1:0]    sel_idx;

   always_comb begin
      swi_dec = '0;
      if (swi_i) swi_dec[swi_lvl_i] = 1'b1;
   end

   assign set_v = req_i | swi_dec;
   assign elig  = pend & ~mask_i;
   assign irq_o = ien_o & sel_valid;
   assign take  = ack_i & irq_o;

   always_comb begin
      clr_v = '0;
      if (take) clr_v[sel_idx] = 1'b1;
   end

   irq_pend_bank #(.N_LVL(N_LVL)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .pend_o(pend)
   );

   irq_prio_sel #(.N_LVL(N_LVL), .HIGH_WINS(HIGH_WINS)) u_sel (
      .elig_i(elig), .valid_o(sel_valid), .idx_o(sel_idx)
   );

   irq_gate_ctl u_gate (
      .clk(clk), .rst_n(rst_n), .take_i(take), .set_i(ien_set_i),
      .ret_i(ret_i), .clr_i(ien_clr_i), .ien_o(ien_o)
   );

   assign lvl_o = sel_valid ? sel_idx : '0;
   assign vec_o = sel_valid ? VEC_W'(VEC_BASE + 32'(sel_idx) * VEC_STRIDE) : '0;

   p_ack_drops_ien_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !ien_o);
   p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ien_o |-> !irq_o);
   p_masked_never_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !mask_i[lvl_o]);

endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 200000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] req_i, mask_i;
   logic       swi_i, ien_set_i, ien_clr_i, ack_i, ret_i;
   logic [2:0] swi_lvl_i;
   logic       irq_o, ien_o;
   logic [11:0] vec_o;
   logic [2:0]  lvl_o;

   int n_checks = 0;
   int n_fail   = 0;

   logic [7:0] m_pend;
   logic       m_ien;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .swi_i(swi_i), .swi_lvl_i(swi_lvl_i),
      .mask_i(mask_i), .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i), .ack_i(ack_i),
      .ret_i(ret_i), .irq_o(irq_o), .vec_o(vec_o), .lvl_o(lvl_o), .ien_o(ien_o)
   );

   function automatic int winner(logic [7:0] pend, logic [7:0] msk);
      int w = -1;
      for (int i = 0; i < 8; i++) if (pend[i] && !msk[i]) w = i;
      return w;
   endfunction

   task automatic cmp(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      int w = winner(m_pend, mask_i);
      cmp(tag, "ien_o", int'(ien_o), int'(m_ien));
      cmp(tag, "irq_o", int'(irq_o), (m_ien && w >= 0) ? 1 : 0);
      cmp(tag, "lvl_o", int'(lvl_o), (w >= 0) ? w : 0);
      cmp(tag, "vec_o", int'(vec_o), (w >= 0) ? 32'h40 + 8 * w : 0);
   endtask

   task automatic step(string tag, logic [7:0] rq, logic sw, logic [2:0] swl,
                       logic [7:0] msk, logic st, logic cl, logic ak, logic rt);
      int w;
      logic take;
      logic [7:0] np;
      req_i = rq; swi_i = sw; swi_lvl_i = swl; mask_i = msk;
      ien_set_i = st; ien_clr_i = cl; ack_i = ak; ret_i = rt;
      w = winner(m_pend, msk);
      take = ak && m_ien && (w >= 0);
      np = m_pend;
      if (take) np[w] = 1'b0;
      np = np | rq;
      if (sw) np[swl] = 1'b1;
      @(posedge clk);
      m_pend = np;
      if (take || cl)   m_ien = 1'b0;
      else if (st || rt) m_ien = 1'b1;
      @(negedge clk);
      req_i = '0; swi_i = 1'b0; ien_set_i = 1'b0; ien_clr_i = 1'b0;
      ack_i = 1'b0; ret_i = 1'b0;
      check_all(tag);
   endtask

   initial begin
      #(CLK_PERIOD * MAX_CYCLES);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      rst_n = 1'b0;
      req_i = '0; mask_i = '0; swi_i = 0; swi_lvl_i = '0;
      ien_set_i = 0; ien_clr_i = 0; ack_i = 0; ret_i = 0;
      m_pend = '0; m_ien = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");

      // R4: latch with enable clear, then present after enable
      step("R4 latched while disabled", 8'h24, 0, 3'd0, 8'h00, 0, 0, 0, 0);
      step("R4 ack ignored when disabled R7", 8'h00, 0, 3'd0, 8'h00, 0, 0, 1, 0);
      step("R4 enable presents R6", 8'h00, 0, 3'd0, 8'h00, 1, 0, 0, 0);
      // R5: mask level 5, level 2 wins
      step("R5 mask high level", 8'h00, 0, 3'd0, 8'h20, 0, 0, 0, 0);
      // R7/R8: ack clears level 2 and enable
      step("R7 ack clears one level R8", 8'h00, 0, 3'd0, 8'h20, 0, 0, 1, 0);
      step("R8 ret restores enable R5", 8'h00, 0, 3'd0, 8'h20, 0, 0, 0, 1);
      step("R5 unmask presents R9", 8'h00, 0, 3'd0, 8'h00, 0, 0, 0, 0);
      // R3: software interrupt level 7
      step("R3 software strobe", 8'h00, 1, 3'd7, 8'h00, 0, 0, 0, 0);
      // R7: ack with same-level request keeps latch
      step("R7 set beats clear", 8'h80, 0, 3'd0, 8'h00, 0, 0, 1, 0);
      // R8: clear beats set
      step("R8 clear over set", 8'h00, 0, 3'd0, 8'h00, 1, 1, 0, 0);
      step("R8 set enable", 8'h00, 0, 3'd0, 8'h00, 1, 0, 0, 0);
      step("R2 one-edge request R6", 8'h01, 0, 3'd0, 8'h80, 0, 0, 0, 0);

      for (int k = 0; k < 3000; k++) begin
         logic [7:0] rq, mk;
         int r;
         rq = 8'($urandom) & 8'($urandom) & 8'($urandom);
         mk = 8'($urandom) & 8'($urandom);
         r  = $urandom % 16;
         step("R2 R6 R7 R8 R9 random", rq, ($urandom % 6) == 0, 3'($urandom), mk,
              r == 0, r == 1, ($urandom % 3) == 0, r == 2 || r == 3);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule